// File: doc/BRIEF.md
# Voice-Coil Driver Register Target on a Two-Wire Bus

This block is the control-register front end of a lens-focus coil driver. It sits on an I2C bus as a target at the fixed 7-bit address 0x0E. It samples SCL and SDA with the system clock and finds start, stop and repeated-start conditions. It then serves a small register map through one byte-wide register pointer. After the address byte, the first byte of a write transfer loads the pointer. Every later byte is stored at the pointer, and the pointer then steps by one. A read transfer returns the register at the pointer and steps it after each byte. The pointer is kept between transfers, so a read that does not load the pointer first continues from where the last access stopped.

The map holds the following registers. A control byte carries a ringing-compensation enable and a self-clearing soft-reset bit. The 10-bit coil current code is split over a high byte and a low byte. A read-only status byte mirrors five fault inputs. A mode byte holds the settling choice, the PWM/linear choice and a 3-bit PWM frequency code. The last register is an 8-bit resonance code. The decoded fields leave the block as plain outputs for the analog driver. The coil current code changes only when the low byte is written, so the driver never sees half of a two-byte update.

Top module: `vcm_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0x0E. Bit 0 of that byte selects the direction: 0 is write and 1 is read. On a mismatch it leaves SDA released and ignores all bytes until the next start.
- R2: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments by one. The target acknowledges every byte it receives.
- R3: In a read transfer, the target sends the register at the pointer, MSB first, and increments the pointer after each byte. It sends another byte for as long as the controller acknowledges. After a not-acknowledge it releases SDA.
- R4: The target samples SDA on the rising edge of SCL. It changes its SDA drive only while SCL is low. It holds an acknowledge low from the falling edge after the eighth bit until the next falling edge.
- R5: After reset the registers hold their defaults and the pointer is 0. The control byte reads 0x02, so ringing compensation is enabled. The coil code is 0, the mode byte is 0x00 and the resonance code is 0x83.
- R6: Register 0x03 holds current bits [9:8] in its bits [1:0], as a pending value that can be read back. Writing register 0x04 commits the coil code as {pending bits, written byte}. A write to 0x03 alone does not change the coil code.
- R7: In control register 0x02, bit 1 is the ringing enable and can be read and written. Writing a 1 to bit 0 returns every register to its default and pulses `sw_reset` high for one clock; the other bits of that byte are discarded. Bit 0 always reads 0.
- R8: In mode register 0x06, bit 0 drives `settle_fast`, bit 1 drives `lin_sel` and bits [4:2] drive `pwm_code`. Bits [7:5] are not stored and read as 0.
- R9: Status register 0x05 reads as {3'b000, status_i[4:0]}. The bits are, from bit 0 up: overcurrent, undervoltage, open coil, shorted coil, over-temperature. Writes to it have no effect.
- R10: Addresses other than 0x02 to 0x07 read as 0x00, and writes to them have no effect. Unused bits of the implemented registers read as 0.
- R11: A repeated start ends the current transfer without changing the pointer. A later read that does not load the pointer first returns data from the pointer left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| status_i | input | 5 | Fault flags shown in the status register |
| ring_en | output | 1 | Ringing-compensation enable |
| coil_code | output | 10 | Committed coil current code |
| settle_fast | output | 1 | Settling mode select from the mode register |
| lin_sel | output | 1 | Output-stage select: 1 is linear, 0 is PWM |
| pwm_code | output | 3 | PWM switching-frequency code |
| res_code | output | 8 | Resonance code for the ringing compensation |
| sw_reset | output | 1 | One-clock pulse after a soft reset |

## Verification
The properties assume that each SCL high and low phase lasts longer than the three-clock latency of the line sampler. They also assume that the controller moves SDA only while SCL is low, except for start and stop. Under those conditions every change of the target's drive falls inside a low phase. The bench holds each SCL phase for ten system clocks. It changes SDA two clocks after a falling edge. It never attempts a start or stop while the target owns the data line.

// File: rtl/vcm_i2c_pkg.sv
package vcm_i2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 10;
    localparam int HI_W     = CODE_W - BYTE_W;
    localparam int STAT_W   = 5;
    localparam int MODE_W   = 5;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    localparam logic [6:0] TARGET_ADDR = 7'h0E;

    localparam logic [BYTE_W-1:0] A_CTRL   = 8'h02;
    localparam logic [BYTE_W-1:0] A_CUR_HI = 8'h03;
    localparam logic [BYTE_W-1:0] A_CUR_LO = 8'h04;
    localparam logic [BYTE_W-1:0] A_STAT   = 8'h05;
    localparam logic [BYTE_W-1:0] A_MODE   = 8'h06;
    localparam logic [BYTE_W-1:0] A_RES    = 8'h07;

    localparam logic [BYTE_W-1:0] RES_DEFAULT = 8'h83;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_evt_t;

    typedef struct packed {
        logic              ring_en;
        logic [HI_W-1:0]   cur_hi;
        logic [BYTE_W-1:0] cur_lo;
        logic [CODE_W-1:0] coil;
        logic [MODE_W-1:0] mode;
        logic [BYTE_W-1:0] res;
    } reg_file_t;

    function automatic reg_file_t reg_defaults();
        reg_file_t r;
        r.ring_en = 1'b1;
        r.cur_hi  = '0;
        r.cur_lo  = '0;
        r.coil    = '0;
        r.mode    = '0;
        r.res     = RES_DEFAULT;
        return r;
    endfunction

endpackage

// File: rtl/vcm_line_sync.sv
module vcm_line_sync
    import vcm_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_now = scl_sh[STAGES-1];
    assign sda_now = sda_sh[STAGES-1];

    always_comb begin
        evt.rise  = ~scl_q & scl_now;
        evt.fall  = scl_q & ~scl_now;
        evt.start = scl_q & scl_now & sda_q & ~sda_now;
        evt.stop  = scl_q & scl_now & ~sda_q & sda_now;
        evt.sda   = sda_now;
    end

endmodule

// File: rtl/vcm_i2c_engine.sv
module vcm_i2c_engine
    import vcm_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = TARGET_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] LAST = BITCNT_W'(BYTE_W - 1);

    bus_state_e          state;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic                rw;
    logic                ptr_next;
    logic                mack;

    assign wr_en   = (state == ST_WRITE) && evt.fall && (bit_cnt == FULL) && !ptr_next;
    assign wr_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            ptr_next <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WRITE: begin
                    if (evt.rise && bit_cnt < FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (evt.fall && bit_cnt == FULL) begin
                        if (state == ST_ADDR) begin
                            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                state    <= ST_ADDR_ACK;
                                sda_oe   <= 1'b1;
                                rw       <= shreg[0];
                                ptr_next <= ~shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state  <= ST_WRITE_ACK;
                            sda_oe <= 1'b1;
                            if (ptr_next) begin
                                ptr      <= shreg;
                                ptr_next <= 1'b0;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            state  <= ST_READ;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            state  <= ST_WRITE;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WRITE_ACK: begin
                    if (evt.fall) begin
                        state   <= ST_WRITE;
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                    end
                end
                ST_READ: begin
                    if (evt.fall) begin
                        if (bit_cnt == LAST) begin
                            state  <= ST_READ_ACK;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~shreg[BYTE_W-2];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_READ_ACK: begin
                    if (evt.rise) begin
                        mack <= ~evt.sda;
                    end else if (evt.fall) begin
                        if (mack) begin
                            state   <= ST_READ;
                            bit_cnt <= '0;
                            shreg   <= rd_data;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vcm_reg_bank.sv
module vcm_reg_bank
    import vcm_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [STAT_W-1:0] status_i,
    output logic [BYTE_W-1:0] rd_data,
    output reg_file_t         regs,
    output logic              sw_reset
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= reg_defaults();
            sw_reset <= 1'b0;
        end else begin
            sw_reset <= 1'b0;
            if (wr_en) begin
                case (ptr)
                    A_CTRL: begin
                        if (wr_data[0]) begin
                            regs     <= reg_defaults();
                            sw_reset <= 1'b1;
                        end else begin
                            regs.ring_en <= wr_data[1];
                        end
                    end
                    A_CUR_HI: regs.cur_hi <= wr_data[HI_W-1:0];
                    A_CUR_LO: begin
                        regs.cur_lo <= wr_data;
                        regs.coil   <= {regs.cur_hi, wr_data};
                    end
                    A_MODE:   regs.mode <= wr_data[MODE_W-1:0];
                    A_RES:    regs.res  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (ptr)
            A_CTRL:   rd_data[1]          = regs.ring_en;
            A_CUR_HI: rd_data[HI_W-1:0]   = regs.cur_hi;
            A_CUR_LO: rd_data             = regs.cur_lo;
            A_STAT:   rd_data[STAT_W-1:0] = status_i;
            A_MODE:   rd_data[MODE_W-1:0] = regs.mode;
            A_RES:    rd_data             = regs.res;
            default:  rd_data             = '0;
        endcase
    end

endmodule

// File: rtl/vcm_i2c_target.sv
module vcm_i2c_target
    import vcm_i2c_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = TARGET_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STAT_W-1:0] status_i,
    output logic              ring_en,
    output logic [CODE_W-1:0] coil_code,
    output logic              settle_fast,
    output logic              lin_sel,
    output logic [2:0]        pwm_code,
    output logic [BYTE_W-1:0] res_code,
    output logic              sw_reset
);
    line_evt_t         evt;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] cur_ptr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    reg_file_t         regs;

    vcm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    vcm_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .ptr     (cur_ptr),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    vcm_reg_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .ptr      (cur_ptr),
        .wr_data  (wr_data),
        .status_i (status_i),
        .rd_data  (rd_data),
        .regs     (regs),
        .sw_reset (sw_reset)
    );

    assign ring_en     = regs.ring_en;
    assign coil_code   = regs.coil;
    assign settle_fast = regs.mode[0];
    assign lin_sel     = regs.mode[1];
    assign pwm_code    = regs.mode[4:2];
    assign res_code    = regs.res;

endmodule

// File: rtl/vcm_i2c_target_chk.sv
module vcm_i2c_target_chk
    import vcm_i2c_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              sw_reset,
    input logic              wr_en,
    input logic [CODE_W-1:0] coil_code,
    input logic [BYTE_W-1:0] res_code,
    input logic [BYTE_W-1:0] cur_ptr
);
    // R4: drive changes only inside an SCL low phase
    a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R2: a stored byte advances the pointer by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cur_ptr == $past(cur_ptr) + 8'd1));

    // R6: coil code moves only on a low-byte write or a soft reset
    a_r6_commit_low: assert property (@(posedge clk) disable iff (rst)
        (coil_code != $past(coil_code)) |->
            (($past(wr_en) && $past(cur_ptr) == A_CUR_LO) || sw_reset));

    // R10: resonance code moves only on its own write or a soft reset
    a_r10_res_guard: assert property (@(posedge clk) disable iff (rst)
        (res_code != $past(res_code)) |->
            (($past(wr_en) && $past(cur_ptr) == A_RES) || sw_reset));

    // R7: soft reset indication lasts one clock
    a_r7_reset_pulse: assert property (@(posedge clk) disable iff (rst)
        sw_reset |=> !sw_reset);

endmodule

bind vcm_i2c_target vcm_i2c_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .sw_reset  (sw_reset),
    .wr_en     (wr_en),
    .coil_code (coil_code),
    .res_code  (res_code),
    .cur_ptr   (cur_ptr)
);

// File: tb/vcm_i2c_target_tb.sv
module vcm_i2c_target_tb;
    import vcm_i2c_pkg::*;

    localparam int H = 10;
    localparam logic [7:0] AW = {TARGET_ADDR, 1'b0};
    localparam logic [7:0] AR = {TARGET_ADDR, 1'b1};
    localparam logic [4:0] STAT_VAL = 5'h15;

    // {requirement number, pointer, written byte, expected readback}
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        32'h07_02_02_02,   // R7 ring enable set
        32'h07_02_00_00,   // R7 ring enable cleared
        32'h0A_02_FE_02,   // R10 unused control bits read 0
        32'h06_03_FF_03,   // R6 high part keeps two bits
        32'h06_04_A5_A5,   // R6 low byte
        32'h09_05_FF_15,   // R9 status mirrors inputs, write ignored
        32'h08_06_FF_1F,   // R8 mode keeps five bits
        32'h08_06_E9_09,   // R8 mode second pattern
        32'h02_07_3C_3C,   // R2 resonance code stored
        32'h0A_01_55_00,   // R10 hole below map
        32'h0A_08_77_00,   // R10 hole above map
        32'h0A_00_12_00    // R10 address zero
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    logic        ring_en, settle_fast, lin_sel, sw_reset;
    logic [9:0]  coil_code;
    logic [2:0]  pwm_code;
    logic [7:0]  res_code;

    int n_tests = 0;
    int n_fail  = 0;
    int nack_cnt = 0;
    int rst_pulses = 0;
    int oe_glitch = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    vcm_i2c_target u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .status_i    (STAT_VAL),
        .ring_en     (ring_en),
        .coil_code   (coil_code),
        .settle_fast (settle_fast),
        .lin_sel     (lin_sel),
        .pwm_code    (pwm_code),
        .res_code    (res_code),
        .sw_reset    (sw_reset)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_prev && m_scl && sda_oe != oe_prev) oe_glitch++;
            if (sw_reset) rst_pulses++;
        end
        scl_prev = m_scl;
        oe_prev  = sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H / 2);
        b = sda_bus;  tick(H - H / 2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic nb;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(nb);
        ack = ~nb;
    endtask

    task automatic send_chk(input logic [7:0] d);
        logic a;
        send_byte(d, a);
        if (!a) nack_cnt++;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic write_reg(input logic [7:0] ptr, input logic [7:0] d);
        bus_start(); send_chk(AW); send_chk(ptr); send_chk(d); bus_stop();
    endtask

    task automatic write_two(input logic [7:0] ptr, input logic [7:0] d0, input logic [7:0] d1);
        bus_start(); send_chk(AW); send_chk(ptr); send_chk(d0); send_chk(d1); bus_stop();
    endtask

    task automatic read_at(input logic [7:0] ptr, input int n, output logic [7:0] q [4]);
        bus_start(); send_chk(AW); send_chk(ptr);
        bus_start(); send_chk(AR);
        for (int i = 0; i < n; i++) recv_byte(q[i], i != n - 1);
        bus_stop();
    endtask

    task automatic read_cur(input int n, output logic [7:0] q [4]);
        bus_start(); send_chk(AR);
        for (int i = 0; i < n; i++) recv_byte(q[i], i != n - 1);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R4 watchdog: actual hung transfer expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] q [4];
        logic       a;

        tick(5);
        rst = 1'b0;
        tick(5);

        // R5 reset state
        check("R5 ring_en", ring_en, 1);
        check("R5 coil", coil_code, 0);
        check("R5 res", res_code, 8'h83);
        check("R5 mode", {pwm_code, lin_sel, settle_fast}, 0);
        check("R5 sda_oe", sda_oe, 0);
        read_cur(1, q);
        check("R5 pointer zero read", q[0], 8'h00);

        // Table walk: write one byte, read it back from a set pointer
        for (int v = 0; v < NV; v++) begin
            write_reg(VEC[v][23:16], VEC[v][15:8]);
            read_at(VEC[v][23:16], 1, q);
            check($sformatf("R%0d vec%0d", VEC[v][31:24], v), q[0], VEC[v][7:0]);
        end
        check("R2 all bytes acked", nack_cnt, 0);
        check("R6 coil after table", coil_code, 10'h3A5);
        check("R8 decode", {pwm_code, lin_sel, settle_fast}, 5'b010_0_1);
        check("R7 ring bit", ring_en, 1);

        // R6 high byte alone stays pending
        write_reg(8'h03, 8'h01);
        check("R6 pending no commit", coil_code, 10'h3A5);
        read_at(8'h03, 1, q);
        check("R6 pending readback", q[0], 8'h01);
        write_reg(8'h04, 8'h5A);
        check("R6 commit", coil_code, 10'h15A);
        write_two(8'h03, 8'h02, 8'h11);
        check("R6 burst commit", coil_code, 10'h211);

        // R2 sequential write
        write_two(8'h06, 8'h16, 8'h71);
        check("R2 mode seq", {pwm_code, lin_sel, settle_fast}, 5'b101_1_0);
        check("R2 res seq", res_code, 8'h71);

        // R3 sequential read from set pointer
        read_at(8'h06, 3, q);
        check("R3 seq byte0", q[0], 8'h16);
        check("R3 seq byte1", q[1], 8'h71);
        check("R3 seq byte2", q[2], 8'h00);

        // R11 pointer persists across transfers
        bus_start(); send_chk(AW); send_chk(8'h05); bus_stop();
        read_cur(2, q);
        check("R11 current read status", q[0], 8'h15);
        check("R11 current read mode", q[1], 8'h16);
        read_cur(1, q);
        check("R11 next transfer", q[0], 8'h71);

        // R11 repeated start keeps pointer; R3 NACK releases
        bus_start(); send_chk(AW); send_chk(8'h04);
        bus_start(); send_chk(AR);
        recv_byte(q[0], 1'b1);
        recv_byte(q[1], 1'b0);
        check("R3 released after nack", sda_oe, 0);
        bus_stop();
        check("R11 rs byte0", q[0], 8'h11);
        check("R11 rs byte1", q[1], 8'h15);

        // R1 wrong address ignored
        bus_start(); send_byte(8'h1E, a);
        check("R1 mismatch no ack", a, 0);
        send_byte(8'h07, a);
        send_byte(8'h99, a);
        check("R1 data ignored no ack", a, 0);
        bus_stop();
        check("R1 res unchanged", res_code, 8'h71);
        bus_start(); send_byte(AW, a); bus_stop();
        check("R1 match acked", a, 1);

        // R7 soft reset
        write_reg(8'h02, 8'h01);
        check("R7 one pulse", rst_pulses, 1);
        check("R7 res default", res_code, 8'h83);
        check("R7 coil default", coil_code, 0);
        check("R7 mode default", {pwm_code, lin_sel, settle_fast}, 0);
        check("R7 ring default", ring_en, 1);
        read_at(8'h02, 1, q);
        check("R7 reset bit reads 0", q[0], 8'h02);

        check("R4 no drive change while SCL high", oe_glitch, 0);
        check("R2 acks overall", nack_cnt, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule